// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Host Receiver

This block is the host end of the reverse channel in an enhanced parallel port link, where bytes flow from the peripheral to the host. The host pacing line `hostAck` opens and closes every transfer. The peripheral drives an active-low strobe, `periphStrobe`, together with a data byte. The receiver passes the strobe through a synchronizer and takes the byte when it sees the strobe fall. It then gives the byte to local logic through a valid/ready register.

`hostAck` is raised only at the moment the output register can take the byte. A slow consumer therefore stalls the peripheral and loses nothing. A programmable watchdog raises a sticky error if the strobe stays low too long after `hostAck` has risen. Negotiation of the reverse direction, the forward channel and the pad drivers belong to other blocks. `revEn` only tells this block whether the link is currently reversed.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, `hostAck`, `rxValid` and `timeoutErr` are all low.
- R2: While `revEn` is low, `hostAck` stays low and strobe activity delivers no byte.
- R3: After `revEn` rises, a transfer is accepted only once the strobe has been seen high (the idle level) and then falls. A strobe that is already low at enable time starts nothing.
- R4: The delivered byte is the one present on `periphData` when the strobe fell. Data changes after `hostAck` rises have no effect on it.
- R5: `hostAck` rises only on the clock edge where the byte enters the output register (`rxValid` high). While that register is full and not being read, `hostAck` stays low.
- R6: Once raised, `hostAck` stays high until the synchronized strobe is high again, and then returns low.
- R7: While `rxValid` is high and `rxReady` is low, `rxValid` and `rxData` hold their values.
- R8: `timeoutErr` sets when `hostAck` has been high for more than `timeoutLimit` cycles with the strobe still low. A transfer that completes within the limit never sets it.
- R9: `timeoutErr` stays set while `revEn` is high, through later transfers, and clears when `revEn` is low.
- R10: Bytes reach the local side in the order sent, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| revEn | input | 1 | Link is in reverse direction; low forces the receiver off |
| periphStrobe | input | 1 | Peripheral byte strobe, active low, asynchronous |
| periphData | input | DATA_W | Byte from the peripheral |
| hostAck | output | 1 | Host pacing line: low permits a byte, high accepts it |
| timeoutLimit | input | TMO_W | Watchdog limit in cycles |
| timeoutErr | output | 1 | Sticky strobe-return timeout flag |
| rxData | output | DATA_W | Received byte |
| rxValid | output | 1 | `rxData` holds an unread byte |
| rxReady | input | 1 | Local side takes the byte this cycle |

## Verification
On every cycle the checker confirms several rules. `hostAck` rises only together with a loaded output byte. A stalled output keeps its byte. `hostAck` is low while the link is off and is not released while the strobe is still low. The error flag is sticky and is cleared by disabling. Only the bench scenarios can show the rest. These are that the byte taken is the one present at the strobe fall rather than later data, that a strobe already low at enable is ignored, that the watchdog fires after the limit and not before, and that order is preserved under backpressure.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_IDLE = 2'd1,
    ST_HOLD = 2'd2,
    ST_ACK  = 2'd3
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch periphData into the staging register
    logic load;     // move staging register to output register
    logic tmoRun;   // hostAck high, watchdog counting
    logic errClr;   // clear sticky timeout flag
  } ctrlStb_t;
endpackage

// File: rtl/ecp_rev_dp.sv
module ecp_rev_dp
  import ecp_rev_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periphStrobe,
  input  logic [DATA_W-1:0] periphData,
  input  ctrlStb_t          stb,
  input  logic              rxReady,
  input  logic [TMO_W-1:0]  timeoutLimit,
  output logic              stbHigh,
  output logic              stbFall,
  output logic              outFree,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              timeoutErr
);
  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   stbPrev;
  logic [DATA_W-1:0]      stageReg;
  logic [TMO_W-1:0]       tmoCnt;

  // synchronizer, resets to the idle (high) level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
      stbPrev   <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], periphStrobe};
      stbPrev   <= syncChain[SYNC_STAGES-1];
    end
  end

  assign stbHigh = syncChain[SYNC_STAGES-1];
  assign stbFall = stbPrev & ~syncChain[SYNC_STAGES-1];

  // staging register: byte held between strobe fall and output load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageReg <= '0;
    else if (stb.capture) stageReg <= periphData;
  end

  // output register with valid/ready
  assign outFree = ~rxValid | rxReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxData  <= '0;
    end else if (stb.load) begin
      rxValid <= 1'b1;
      rxData  <= stageReg;
    end else if (rxValid && rxReady) begin
      rxValid <= 1'b0;
    end
  end

  // strobe-return watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmoCnt <= '0;
    else if (!stb.tmoRun) tmoCnt <= '0;
    else if (tmoCnt != CNT_MAX) tmoCnt <= tmoCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeoutErr <= 1'b0;
    else if (stb.errClr) timeoutErr <= 1'b0;
    else if (stb.tmoRun && !stbHigh && tmoCnt >= timeoutLimit) timeoutErr <= 1'b1;
  end
endmodule

// File: rtl/ecp_rev_ctrl.sv
module ecp_rev_ctrl
  import ecp_rev_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     revEn,
  input  logic     stbHigh,
  input  logic     stbFall,
  input  logic     outFree,
  output logic     hostAck,
  output ctrlStb_t stb
);
  rxState_t state, stateNxt;

  always_comb begin
    stateNxt    = state;
    stb         = '0;
    stb.errClr  = ~revEn;
    stb.tmoRun  = (state == ST_ACK);
    if (!revEn) begin
      stateNxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:  if (stbHigh) stateNxt = ST_IDLE;
        ST_IDLE: if (stbFall) begin
                   stb.capture = 1'b1;
                   stateNxt    = ST_HOLD;
                 end
        ST_HOLD: if (outFree) begin
                   stb.load = 1'b1;
                   stateNxt = ST_ACK;
                 end
        ST_ACK:  if (stbHigh) stateNxt = ST_IDLE;
        default: stateNxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNxt;
  end

  assign hostAck = (state == ST_ACK);
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
  import ecp_rev_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              revEn,
  input  logic              periphStrobe,
  input  logic [DATA_W-1:0] periphData,
  output logic              hostAck,
  input  logic [TMO_W-1:0]  timeoutLimit,
  output logic              timeoutErr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady
);
  ctrlStb_t stb;
  logic     stbHigh, stbFall, outFree;

  ecp_rev_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .revEn(revEn),
    .stbHigh(stbHigh), .stbFall(stbFall), .outFree(outFree),
    .hostAck(hostAck), .stb(stb)
  );

  ecp_rev_dp #(.DATA_W(DATA_W), .TMO_W(TMO_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .periphStrobe(periphStrobe), .periphData(periphData),
    .stb(stb), .rxReady(rxReady), .timeoutLimit(timeoutLimit),
    .stbHigh(stbHigh), .stbFall(stbFall), .outFree(outFree),
    .rxData(rxData), .rxValid(rxValid), .timeoutErr(timeoutErr)
  );
endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              revEn,
  input logic              periphStrobe,
  input logic              hostAck,
  input logic              timeoutErr,
  input logic [DATA_W-1:0] rxData,
  input logic              rxValid,
  input logic              rxReady
);
  AST_ACK_WITH_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostAck) |-> rxValid); // R5

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxReady |=> rxValid && $stable(rxData)); // R7

  AST_OFF_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !revEn |=> !hostAck); // R2

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    hostAck && !periphStrobe && revEn |=> hostAck); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr && revEn |=> timeoutErr); // R9

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !revEn |=> !timeoutErr); // R9

  AST_ERR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> $past(hostAck)); // R8
endmodule

bind ecp_rev_rx ecp_rev_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .revEn(revEn), .periphStrobe(periphStrobe),
  .hostAck(hostAck), .timeoutErr(timeoutErr), .rxData(rxData),
  .rxValid(rxValid), .rxReady(rxReady)
);

// File: tb/ecp_rev_rx_tb.sv
module ecp_rev_rx_tb;
  logic        clk = 1'b0;
  logic        rstN, revEn, periphStrobe, rxReady;
  logic [7:0]  periphData;
  logic [15:0] timeoutLimit;
  logic        hostAck, timeoutErr, rxValid;
  logic [7:0]  rxData;

  logic [7:0] expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ecp_rev_rx u_dut (
    .clk(clk), .rstN(rstN), .revEn(revEn), .periphStrobe(periphStrobe),
    .periphData(periphData), .hostAck(hostAck), .timeoutLimit(timeoutLimit),
    .timeoutErr(timeoutErr), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady)
  );

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setReady(logic v);
    @(posedge clk);
    #2 rxReady = v;
  endtask

  // peripheral model: one full interlocked byte
  task automatic sendByte(logic [7:0] b);
    expQ.push_back(b);
    while (hostAck) @(negedge clk);
    periphData = b;
    waitCyc(2);
    periphStrobe = 1'b0;
    while (!hostAck) @(negedge clk);
    periphData = ~b;  // late change must not be seen (R4)
    waitCyc(2);
    periphStrobe = 1'b1;
    waitCyc(1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rxValid && rxReady) begin
      if (expQ.size() == 0) check(1'b0, "R10 unexpected byte", rxData, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(rxData == e, "R4 R10 byte", rxData, e);
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
    end
  end

  initial begin
    rstN = 1'b0; revEn = 1'b0; periphStrobe = 1'b1; rxReady = 1'b1;
    periphData = 8'h00; timeoutLimit = 16'd20;
    waitCyc(5);
    check(hostAck == 1'b0, "R1 hostAck", hostAck, 0);
    check(rxValid == 1'b0, "R1 rxValid", rxValid, 0);
    check(timeoutErr == 1'b0, "R1 timeoutErr", timeoutErr, 0);
    rstN = 1'b1;
    waitCyc(3);

    // R2: disabled link ignores strobe
    periphData = 8'hE7; periphStrobe = 1'b0;
    waitCyc(10);
    check(hostAck == 1'b0, "R2 hostAck", hostAck, 0);
    check(rxValid == 1'b0, "R2 rxValid", rxValid, 0);

    // R3: strobe low at enable starts nothing
    revEn = 1'b1;
    waitCyc(15);
    check(hostAck == 1'b0, "R3 hostAck", hostAck, 0);
    check(rxValid == 1'b0, "R3 rxValid", rxValid, 0);
    periphStrobe = 1'b1;
    waitCyc(4);

    // R4 R10: ordinary stream
    sendByte(8'hA5);
    sendByte(8'h3C);
    sendByte(8'h00);
    sendByte(8'hFF);
    sendByte(8'h81);
    waitCyc(4);
    check(timeoutErr == 1'b0, "R8 no error in time", timeoutErr, 0);

    // R6: hostAck held while strobe low, dropped after it rises
    expQ.push_back(8'h5A);
    periphData = 8'h5A; waitCyc(2); periphStrobe = 1'b0;
    while (!hostAck) @(negedge clk);
    waitCyc(10);
    check(hostAck == 1'b1, "R6 held", hostAck, 1);
    periphStrobe = 1'b1;
    waitCyc(6);
    check(hostAck == 1'b0, "R6 released", hostAck, 0);

    // R5 R7: backpressure
    setReady(1'b0);
    sendByte(8'h11);
    waitCyc(3);
    check(rxValid == 1'b1, "R7 valid", rxValid, 1);
    check(rxData == 8'h11, "R7 data", rxData, 8'h11);
    fork
      sendByte(8'h22);
    join_none
    waitCyc(30);
    check(hostAck == 1'b0, "R5 no ack when full", hostAck, 0);
    check(rxData == 8'h11, "R7 data held", rxData, 8'h11);
    setReady(1'b1);
    waitCyc(30);

    // R8: timeout
    expQ.push_back(8'h77);
    periphData = 8'h77; waitCyc(2); periphStrobe = 1'b0;
    while (!hostAck) @(negedge clk);
    waitCyc(40);
    check(timeoutErr == 1'b1, "R8 timeout", timeoutErr, 1);
    periphStrobe = 1'b1;
    waitCyc(6);

    // R9: sticky, then cleared by disable
    sendByte(8'h99);
    waitCyc(3);
    check(timeoutErr == 1'b1, "R9 sticky", timeoutErr, 1);
    revEn = 1'b0;
    waitCyc(2);
    check(timeoutErr == 1'b0, "R9 cleared", timeoutErr, 0);
    revEn = 1'b1;
    waitCyc(4);
    sendByte(8'h42);

    for (int i = 0; i < 200 && expQ.size() != 0; i++) waitCyc(1);
    check(expQ.size() == 0, "R10 all delivered", expQ.size(), 0);
    summary();
  end
endmodule